// File: doc/BRIEF.md
# Asynchronous Serial Communications Controller

This block is a byte-wide, register-mapped asynchronous serial port. A host reads and writes five byte registers to set the character length, enable the transmitter and receiver, pick interrupt sources, load characters to send, and collect received characters with their status. The block has a transmit shifter that sends one frame per bit time, and a receiver that oversamples the line sixteen times per bit. It also keeps the status flags and drives a single interrupt request line.

Bit timing comes from outside. A separate baud generator supplies a one-cycle strobe per bit time for the transmitter and a one-cycle strobe at sixteen times that rate for the receiver. The baud register is stored and read back for that generator's use. A bootstrap-mode input, sampled while reset is high, picks the reset values of the baud and second control registers. The receiver wake-up, address-mark wake, break and noise-filter controls are stored and have no effect.

Received error and data flags clear in two steps: the host reads status, then reads data, and only the flags seen in that status read are cleared.

Top module: `sci_ctrl`

## Requirements
- R1: After reset with `boot_mode` low, the registers read: baud (address 0) 0x00, control 1 (address 1) 0x00, control 2 (address 2) 0x00, status (address 3) 0xC0. Status bits are TDRE=7, TC=6, RDRF=5, IDLE=4, OR=3, NF=2, FE=1, and bit 0 reads 0. `irq` is low.
- R2: With `boot_mode` high during reset, baud reads 0x33 and control 2 reads 0x12 after reset.
- R3: Each frame is sent LSB first, as one low start bit, then the data bits, then one high stop bit, at one bit per `bit_tick`. Control 1 bit 4 (M) set gives 9 data bits, whose ninth bit is control 1 bit 6 (T8) at the time of the data write. M clear gives 8 data bits. `txd` idles high.
- R4: An accepted write to the data register (address 4) clears TDRE. Starting a frame (control 2 bit 3 TE set, data pending) clears TC. Both flags return to 1 one bit time after the stop bit has been driven.
- R5: A write to the data register while TDRE is 0 is ignored: no second frame follows.
- R6: A received character sets RDRF and is read from the data register. In 9-bit mode its ninth bit reads as control 1 bit 7 (R8).
- R7: If a character completes while RDRF is set, OR is set, RDRF stays set, and the data register holds the newer character.
- R8: A character whose stop bit samples low sets FE.
- R9: A status read followed by a data read clears exactly the RDRF, IDLE, OR, NF and FE flags seen in that status read. A data read without a preceding status read clears nothing.
- R10: A character that completes between the status read and the data read cancels the pending clear.
- R11: With control 2 bit 2 (RE) clear, the receiver ignores the line and the receive flags and data keep their values.
- R12: `irq` = (TIE & TDRE) | (TCIE & TC) | (RIE & (RDRF | OR)) | (ILIE & IDLE). The control 2 bit positions are TIE=7, TCIE=6, RIE=5, ILIE=4.
- R13: Writes to the status register have no effect.
- R14: After a received character, one full frame time (frame bits times 16 sample ticks) of continuously high line sets IDLE once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_mode | input | 1 | Chooses the bootstrap reset values while `rst` is high |
| smp_tick | input | 1 | Receive sample strobe, 16 per bit time |
| bit_tick | input | 1 | Transmit bit strobe, 1 per bit time |
| bus_addr | input | 3 | Register address 0..4 |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; applies read side effects |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| rxd | input | 1 | Serial receive line (asynchronous) |
| txd | output | 1 | Serial transmit line |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a character that lands between the status read and the data read of the clearing sequence. The bench reads status while one character is held unread, sends a second complete frame, and only then reads data. It expects the overrun and full flags to survive. The ignored data write is made at a chosen bit of an active frame, from cycle-counted sampling of `txd`. The bench then watches the line stay idle for several bit times. Idle detection is reached by holding the line high for longer than a frame after a character.

// File: rtl/sci_pkg.sv
`timescale 1ns/1ps
package sci_pkg;
    localparam int ADDR_W = 3;
    localparam int BUS_W  = 8;
    localparam int OVS    = 16;   // sample ticks per bit, power of two

    localparam logic [ADDR_W-1:0] A_BAUD = 3'd0;
    localparam logic [ADDR_W-1:0] A_CTL1 = 3'd1;
    localparam logic [ADDR_W-1:0] A_CTL2 = 3'd2;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd3;
    localparam logic [ADDR_W-1:0] A_DATA = 3'd4;

    // control 1 fields
    localparam int C1_R8 = 7;
    localparam int C1_T8 = 6;
    localparam int C1_M  = 4;
    // control 2 fields
    localparam int C2_TIE  = 7;
    localparam int C2_TCIE = 6;
    localparam int C2_RIE  = 5;
    localparam int C2_ILIE = 4;
    localparam int C2_TE   = 3;
    localparam int C2_RE   = 2;

    localparam logic [BUS_W-1:0] BOOT_BAUD = 8'h33;
    localparam logic [BUS_W-1:0] BOOT_CTL2 = 8'h12;

    typedef struct packed {
        logic tdre;
        logic tc;
        logic rdrf;
        logic idle;
        logic ovr;
        logic nf;
        logic fe;
    } sci_stat_t;

    localparam sci_stat_t STAT_RST  = '{tdre: 1'b1, tc: 1'b1, default: 1'b0};
    localparam sci_stat_t RX_FLAGS  = '{tdre: 1'b0, tc: 1'b0, default: 1'b1};

    typedef struct packed {
        logic [8:0] data;
        logic       ferr;
    } rx_char_t;

    function automatic logic [3:0] frame_len(input logic nine);
        return nine ? 4'd11 : 4'd10;
    endfunction

    function automatic logic [BUS_W-1:0] stat_byte(input sci_stat_t s);
        return {s, 1'b0};
    endfunction
endpackage

// File: rtl/sci_tx.sv
`timescale 1ns/1ps
module sci_tx
    import sci_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_tick,
    input  logic       go,
    input  logic       nine,
    input  logic [8:0] payload,
    output logic       txd,
    output logic       started,
    output logic       finished
);
    logic        busy_q;
    logic [10:0] sh_q;
    logic [3:0]  left_q;

    assign started  = bit_tick && !busy_q && go;
    assign finished = bit_tick && busy_q && (left_q == 4'd0);
    assign txd      = busy_q ? sh_q[0] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            sh_q   <= '1;
            left_q <= '0;
        end else if (bit_tick) begin
            if (!busy_q) begin
                if (go) begin
                    busy_q <= 1'b1;
                    sh_q   <= nine ? {1'b1, payload, 1'b0}
                                   : {2'b11, payload[7:0], 1'b0};
                    left_q <= frame_len(nine) - 4'd1;
                end
            end else if (left_q == 4'd0) begin
                busy_q <= 1'b0;
            end else begin
                sh_q   <= {1'b1, sh_q[10:1]};
                left_q <= left_q - 4'd1;
            end
        end
    end
endmodule

// File: rtl/sci_rx.sv
`timescale 1ns/1ps
module sci_rx
    import sci_pkg::*;
#(
    parameter int OVS_N = OVS
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     en,
    input  logic     nine,
    input  logic     rxd,
    output logic     done,
    output rx_char_t ch,
    output logic     idle_hit
);
    localparam int PH_W = $clog2(OVS_N);
    localparam int MID  = OVS_N / 2 - 1;
    localparam int QW   = $clog2(11 * OVS_N + 1);

    logic            s1_q, s2_q, prev_q;
    logic            active_q, nine_q, armed_q;
    logic [PH_W-1:0] ph_q;
    logic [3:0]      bi_q, last_q;
    logic [8:0]      bits_q;
    logic [QW-1:0]   quiet_q;
    logic [QW-1:0]   idle_lim;
    logic            line, fall, at_mid;

    assign line     = s2_q;
    assign fall     = prev_q && !line;
    assign at_mid   = active_q && (ph_q == PH_W'(MID));
    assign idle_lim = QW'(frame_len(nine_q)) * QW'(OVS_N);

    assign done     = tick && en && at_mid && (bi_q == last_q);
    assign ch.data  = nine_q ? bits_q : {1'b0, bits_q[7:0]};
    assign ch.ferr  = !line;
    assign idle_hit = tick && en && !active_q && armed_q && line
                      && (quiet_q == idle_lim - QW'(1));

    // two-stage synchroniser, edge reference updated on sample ticks
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q   <= 1'b1;
            s2_q   <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            s1_q <= rxd;
            s2_q <= s1_q;
            if (tick) prev_q <= s2_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            active_q <= 1'b0;
            nine_q   <= 1'b0;
            armed_q  <= 1'b0;
            ph_q     <= '0;
            bi_q     <= '0;
            last_q   <= '0;
            bits_q   <= '0;
            quiet_q  <= '0;
        end else if (tick) begin
            if (!active_q) begin
                if (fall) begin
                    active_q <= 1'b1;
                    ph_q     <= PH_W'(1);
                    bi_q     <= '0;
                    nine_q   <= nine;
                    last_q   <= frame_len(nine) - 4'd1;
                    quiet_q  <= '0;
                end else if (armed_q) begin
                    if (!line)         quiet_q <= '0;
                    else if (idle_hit) armed_q <= 1'b0;
                    else               quiet_q <= quiet_q + QW'(1);
                end
            end else begin
                ph_q <= ph_q + PH_W'(1);
                if (at_mid) begin
                    if (bi_q == 4'd0) begin
                        if (line) active_q <= 1'b0;   // false start
                    end else if (bi_q == last_q) begin
                        active_q <= 1'b0;
                        armed_q  <= 1'b1;
                        quiet_q  <= '0;
                    end else begin
                        bits_q[bi_q - 4'd1] <= line;
                    end
                    bi_q <= bi_q + 4'd1;
                end
            end
        end
    end
endmodule

// File: rtl/sci_regs.sv
`timescale 1ns/1ps
module sci_regs
    import sci_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              boot_mode,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              tx_started,
    input  logic              tx_finished,
    input  logic              rx_done,
    input  rx_char_t          rx_ch,
    input  logic              rx_idle,
    output logic              tx_go,
    output logic [8:0]        tx_payload,
    output logic              nine,
    output logic              rx_en,
    output sci_stat_t         stat,
    output logic [BUS_W-1:0]  ctl2_o,
    output logic              irq
);
    logic [BUS_W-1:0] baud_q, ctl2_q, rxd_q;
    logic [BUS_W-2:0] ctl1_q;
    logic             r8_q, pend_q;
    logic [8:0]       txb_q;
    sci_stat_t        cap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            baud_q <= boot_mode ? BOOT_BAUD : '0;
            ctl2_q <= boot_mode ? BOOT_CTL2 : '0;
            ctl1_q <= '0;
            stat   <= STAT_RST;
            cap_q  <= '0;
            rxd_q  <= '0;
            r8_q   <= 1'b0;
            txb_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            // second step of the clearing sequence
            if (bus_rd && bus_addr == A_DATA) begin
                stat.rdrf <= stat.rdrf & ~cap_q.rdrf;
                stat.idle <= stat.idle & ~cap_q.idle;
                stat.ovr  <= stat.ovr  & ~cap_q.ovr;
                stat.nf   <= stat.nf   & ~cap_q.nf;
                stat.fe   <= stat.fe   & ~cap_q.fe;
                cap_q     <= '0;
            end
            if (bus_rd && bus_addr == A_STAT) cap_q <= stat & RX_FLAGS;

            if (bus_wr) begin
                case (bus_addr)
                    A_BAUD: baud_q <= bus_wdata;
                    A_CTL1: ctl1_q <= bus_wdata[BUS_W-2:0];
                    A_CTL2: ctl2_q <= bus_wdata;
                    A_DATA: if (stat.tdre) begin
                        txb_q     <= {ctl1_q[C1_T8], bus_wdata};
                        pend_q    <= 1'b1;
                        stat.tdre <= 1'b0;
                    end
                    default: ;
                endcase
            end

            if (tx_started) begin
                pend_q  <= 1'b0;
                stat.tc <= 1'b0;
            end
            if (tx_finished) begin
                stat.tdre <= 1'b1;
                stat.tc   <= 1'b1;
            end

            if (rx_idle) stat.idle <= 1'b1;
            if (rx_done) begin
                if (stat.rdrf) stat.ovr <= 1'b1;
                stat.rdrf <= 1'b1;
                if (rx_ch.ferr) stat.fe <= 1'b1;
                rxd_q <= rx_ch.data[7:0];
                r8_q  <= rx_ch.data[8];
                cap_q <= '0;
            end
        end
    end

    always_comb begin
        case (bus_addr)
            A_BAUD:  bus_rdata = baud_q;
            A_CTL1:  bus_rdata = {r8_q, ctl1_q};
            A_CTL2:  bus_rdata = ctl2_q;
            A_STAT:  bus_rdata = stat_byte(stat);
            A_DATA:  bus_rdata = rxd_q;
            default: bus_rdata = '0;
        endcase
    end

    assign irq = (ctl2_q[C2_TIE]  && stat.tdre)
              || (ctl2_q[C2_TCIE] && stat.tc)
              || (ctl2_q[C2_RIE]  && (stat.rdrf || stat.ovr))
              || (ctl2_q[C2_ILIE] && stat.idle);

    assign tx_go      = pend_q && ctl2_q[C2_TE];
    assign tx_payload = txb_q;
    assign nine       = ctl1_q[C1_M];
    assign rx_en      = ctl2_q[C2_RE];
    assign ctl2_o     = ctl2_q;
endmodule

// File: rtl/sci_ctrl.sv
`timescale 1ns/1ps
module sci_ctrl
    import sci_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              boot_mode,
    input  logic              smp_tick,
    input  logic              bit_tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              rxd,
    output logic              txd,
    output logic              irq
);
    logic             tx_go, tx_started, tx_finished, nine, rx_en;
    logic             rx_done, rx_idle;
    logic [8:0]       txbuf_w;
    rx_char_t         rx_ch;
    sci_stat_t        stat_w;
    logic [BUS_W-1:0] ctl2_w;

    sci_regs u_regs (
        .clk(clk), .rst(rst), .boot_mode(boot_mode),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_started(tx_started), .tx_finished(tx_finished),
        .rx_done(rx_done), .rx_ch(rx_ch), .rx_idle(rx_idle),
        .tx_go(tx_go), .tx_payload(txbuf_w), .nine(nine), .rx_en(rx_en),
        .stat(stat_w), .ctl2_o(ctl2_w), .irq(irq)
    );

    sci_tx u_tx (
        .clk(clk), .rst(rst), .bit_tick(bit_tick), .go(tx_go),
        .nine(nine), .payload(txbuf_w), .txd(txd),
        .started(tx_started), .finished(tx_finished)
    );

    sci_rx #(.OVS_N(OVS)) u_rx (
        .clk(clk), .rst(rst), .tick(smp_tick), .en(rx_en), .nine(nine),
        .rxd(rxd), .done(rx_done), .ch(rx_ch), .idle_hit(rx_idle)
    );
endmodule

// File: rtl/sci_ctrl_chk.sv
`timescale 1ns/1ps
module sci_ctrl_chk
    import sci_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic              txd,
    input logic              irq,
    input sci_stat_t         stat,
    input logic [BUS_W-1:0]  ctl2,
    input logic [8:0]        tx_buf
);
    AST_TC_LINE_IDLE: assert property (@(posedge clk) disable iff (rst)
        stat.tc |-> txd);                                                 // R4
    AST_TC_FALL_TDRE: assert property (@(posedge clk) disable iff (rst)
        $fell(stat.tc) |-> !stat.tdre);                                   // R4
    AST_WR_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_DATA && !stat.tdre) |=> $stable(tx_buf)); // R5
    AST_OVR_KEEPS_FULL: assert property (@(posedge clk) disable iff (rst)
        $rose(stat.ovr) |-> stat.rdrf);                                   // R7
    AST_RX_OFF_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (!ctl2[C2_RE] && !(bus_rd && bus_addr == A_DATA)) |=>
        ($stable(stat.rdrf) && $stable(stat.ovr) && $stable(stat.fe)
         && $stable(stat.idle)));                                         // R11
    AST_IRQ_RX: assert property (@(posedge clk) disable iff (rst)
        (ctl2[C2_RIE] && (stat.rdrf || stat.ovr)) |-> irq);               // R12
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        (ctl2[7:4] == 4'b0000) |-> !irq);                                 // R12
endmodule

bind sci_ctrl sci_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .txd(txd), .irq(irq), .stat(stat_w),
    .ctl2(ctl2_w), .tx_buf(txbuf_w)
);

// File: tb/tb_sci_ctrl.sv
`timescale 1ns/1ps
module tb_sci_ctrl;
    import sci_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       boot_mode = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       rxd = 1'b1;
    logic       txd, irq;
    logic       smp_tick, bit_tick;
    logic [5:0] tcnt;
    int         cyc = 0;
    int         n_cmp = 0;
    int         n_bad = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) tcnt <= '0;
        else     tcnt <= tcnt + 6'd1;
    end
    assign smp_tick = (tcnt[1:0] == 2'd3);
    assign bit_tick = (tcnt == 6'd63);

    sci_ctrl dut (
        .clk(clk), .rst(rst), .boot_mode(boot_mode),
        .smp_tick(smp_tick), .bit_tick(bit_tick),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rxd(rxd), .txd(txd), .irq(irq)
    );

    // expected status byte from the flag positions in R1
    function automatic int st(input bit tdre, tc, rdrf, idle, ovr, fe);
        return (int'(tdre) << 7) | (int'(tc) << 6) | (int'(rdrf) << 5)
             | (int'(idle) << 4) | (int'(ovr) << 3) | (int'(fe) << 1);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input int exp);
        logic [7:0] v;
        rd(a, v);
        check(req, int'(v), exp);
    endtask

    task automatic wait_until(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic do_reset(input logic boot);
        @(negedge clk);
        rst = 1'b1; boot_mode = boot;
        repeat (3) @(negedge clk);
        rst = 1'b0; boot_mode = 1'b0;
    endtask

    // one frame on rxd: 64 clocks per bit (16 sample ticks of 4 clocks)
    task automatic rx_send(input logic [8:0] d, input int nb, input logic stopv);
        @(negedge clk);
        rxd = 1'b0;
        repeat (64) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            rxd = d[i];
            repeat (64) @(negedge clk);
        end
        rxd = stopv;
        repeat (64) @(negedge clk);
        rxd = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    // samples txd at the middle of each bit; optional probes mid-frame
    task automatic tx_grab(input int n, input bit probe, output logic [10:0] bits,
                           output logic [7:0] mid_stat);
        int t0;
        bits = '1;
        mid_stat = '0;
        while (txd === 1'b1) @(negedge clk);
        t0 = cyc;
        for (int i = 0; i < n; i++) begin
            wait_until(t0 + 32 + 64 * i);
            bits[i] = txd;
            if (probe && i == 2) rd(A_STAT, mid_stat);
            if (probe && i == 3) wr(A_DATA, 8'h3C);   // TDRE clear: ignored
        end
        wait_until(t0 + 64 * n + 8);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [10:0] fr;
        logic [7:0]  ms;
        int          lows;

        do_reset(1'b0);
        // R1 reset state
        rd_chk("R1 baud", A_BAUD, 'h00);
        rd_chk("R1 ctl1", A_CTL1, 'h00);
        rd_chk("R1 ctl2", A_CTL2, 'h00);
        rd_chk("R1 stat", A_STAT, st(1, 1, 0, 0, 0, 0));
        check("R1 irq", int'(irq), 0);

        // R2 bootstrap defaults
        do_reset(1'b1);
        rd_chk("R2 baud", A_BAUD, 'h33);
        rd_chk("R2 ctl2", A_CTL2, 'h12);
        do_reset(1'b0);

        // R4: data write with TE off clears TDRE only
        wr(A_DATA, 8'hA5);
        rd_chk("R4 tdre after write", A_STAT, st(0, 1, 0, 0, 0, 0));
        wr(A_CTL2, 8'h08);
        tx_grab(10, 1'b1, fr, ms);
        check("R4 mid-frame flags", int'(ms), st(0, 0, 0, 0, 0, 0));
        check("R3 8-bit frame", int'(fr[9:0]), int'({1'b1, 8'hA5, 1'b0}));
        rd_chk("R4 flags after frame", A_STAT, st(1, 1, 0, 0, 0, 0));
        // R5: the write made during the frame must not produce a frame
        lows = 0;
        repeat (192) begin
            @(negedge clk);
            if (txd !== 1'b1) lows++;
        end
        check("R5 no second frame", lows, 0);

        // R3 nine-bit frame, T8 = 1
        wr(A_CTL1, 8'h50);
        wr(A_DATA, 8'h0F);
        tx_grab(11, 1'b0, fr, ms);
        check("R3 9-bit frame", int'(fr), int'({1'b1, 1'b1, 8'h0F, 1'b0}));
        rd_chk("R4 flags after 9-bit frame", A_STAT, st(1, 1, 0, 0, 0, 0));
        wr(A_CTL1, 8'h00);

        // R12 transmit interrupt terms
        wr(A_CTL2, 8'h80);
        @(negedge clk);
        check("R12 TIE&TDRE", int'(irq), 1);
        wr(A_CTL2, 8'h40);
        @(negedge clk);
        check("R12 TCIE&TC", int'(irq), 1);

        // receiver on
        wr(A_CTL2, 8'h04);
        @(negedge clk);
        check("R12 no enables", int'(irq), 0);
        rx_send(9'h05A, 8, 1'b1);
        rd_chk("R6 rdrf", A_STAT, st(1, 1, 1, 0, 0, 0));
        rd_chk("R6 data", A_DATA, 'h5A);
        rd_chk("R9 cleared", A_STAT, st(1, 1, 0, 0, 0, 0));

        // R9 data read alone clears nothing (capture already consumed)
        rx_send(9'h011, 8, 1'b1);
        rd_chk("R9 data only", A_DATA, 'h11);
        rd_chk("R9 rdrf kept", A_STAT, st(1, 1, 1, 0, 0, 0));
        rd_chk("R9 data", A_DATA, 'h11);
        rd_chk("R9 cleared 2", A_STAT, st(1, 1, 0, 0, 0, 0));

        // R7 overrun
        rx_send(9'h021, 8, 1'b1);
        rx_send(9'h022, 8, 1'b1);
        rd_chk("R7 or+rdrf", A_STAT, st(1, 1, 1, 0, 1, 0));
        rd_chk("R7 newest data", A_DATA, 'h22);
        rd_chk("R7 cleared", A_STAT, st(1, 1, 0, 0, 0, 0));

        // R10 arrival between status read and data read
        rx_send(9'h031, 8, 1'b1);
        rd_chk("R10 first status", A_STAT, st(1, 1, 1, 0, 0, 0));
        rx_send(9'h032, 8, 1'b1);
        rd_chk("R10 data", A_DATA, 'h32);
        rd_chk("R10 flags survive", A_STAT, st(1, 1, 1, 0, 1, 0));
        rd_chk("R10 data again", A_DATA, 'h32);
        rd_chk("R10 cleared", A_STAT, st(1, 1, 0, 0, 0, 0));

        // R8 framing error
        rx_send(9'h044, 8, 1'b0);
        rd_chk("R8 fe", A_STAT, st(1, 1, 1, 0, 0, 1));
        rd_chk("R8 data", A_DATA, 'h44);
        rd_chk("R8 cleared", A_STAT, st(1, 1, 0, 0, 0, 0));

        // R6 nine-bit receive
        wr(A_CTL1, 8'h10);
        rx_send(9'h1A5, 9, 1'b1);
        rd_chk("R6 9-bit stat", A_STAT, st(1, 1, 1, 0, 0, 0));
        rd_chk("R6 r8 in ctl1", A_CTL1, 'h90);
        rd_chk("R6 9-bit data", A_DATA, 'hA5);
        wr(A_CTL1, 8'h00);

        // R14 idle line and R12 idle interrupt
        rx_send(9'h066, 8, 1'b1);
        repeat (800) @(negedge clk);
        rd_chk("R14 idle set", A_STAT, st(1, 1, 1, 1, 0, 0));
        wr(A_CTL2, 8'h14);
        @(negedge clk);
        check("R12 ILIE&IDLE", int'(irq), 1);
        rd_chk("R14 data", A_DATA, 'h66);
        rd_chk("R14 cleared", A_STAT, st(1, 1, 0, 0, 0, 0));
        @(negedge clk);
        check("R12 idle irq gone", int'(irq), 0);

        // R12 receive interrupt
        wr(A_CTL2, 8'h24);
        rx_send(9'h077, 8, 1'b1);
        check("R12 RIE&RDRF", int'(irq), 1);
        rd_chk("R12 stat", A_STAT, st(1, 1, 1, 0, 0, 0));
        rd_chk("R12 data", A_DATA, 'h77);
        @(negedge clk);
        check("R12 rx irq gone", int'(irq), 0);

        // R11 receiver disabled, R13 status write
        wr(A_CTL2, 8'h04);
        rx_send(9'h055, 8, 1'b1);
        wr(A_CTL2, 8'h00);
        rx_send(9'h056, 8, 1'b1);
        wr(A_STAT, 8'h00);
        rd_chk("R11 R13 flags kept", A_STAT, st(1, 1, 1, 0, 0, 0));
        rd_chk("R11 data kept", A_DATA, 'h55);
        rd_chk("R11 cleared", A_STAT, st(1, 1, 0, 0, 0, 0));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule